// File: doc/BRIEF.md
# Sync-Recovering Pulse Slot Demultiplexer

The block takes one serial line on which four time slots repeat: a short framing pulse in the first slot, then one optional data pulse for each of three channels. It samples the line with a fast local clock and measures how long each pulse stays high. A narrow pulse marks the start of a frame. A wide pulse carries data. Each framing pulse realigns a local four-slot tracker. Each wide pulse that begins in a channel slot becomes a one-clock strobe on that channel's output.

The tracker runs on its own between framing pulses. If framing pulses stop for too long, the block raises a loss flag and stops producing strobes until the next framing pulse arrives. A shared gate timer, whose length is set by an input, defines measurement windows. At the end of each window the block latches the number of strobes each channel produced, pulses a valid flag for one cycle, and starts a new count. A long gate gives a wide count range and so a fine frequency reading.

Top module: `tdm_pulse_demux`

## Requirements
- R1: `line_in` passes through two flip-flops before any measurement. While and right after `rst` is high: `sync_lost`=1, `ch_strobe`=0, `cnt_valid`=0 and `cnt_flat`=0.
- R2: A pulse that is high for at most NOM_W/2 samples is a framing pulse (4 or fewer at the defaults). A longer pulse is a data pulse (5 or more at the defaults).
- R3: The tracker splits each frame into four slots of SLOT_LEN clocks, in the order framing, channel 0, channel 1, channel 2. Every framing pulse resets it to the framing slot. A data pulse belongs to the slot in which its rising edge is sampled.
- R4: A data pulse in slot k (k=1..3) sets `ch_strobe[k-1]` high for exactly one clock. The strobe rises on the third rising clock edge after the first edge that samples the line low. At most one strobe bit is high at a time.
- R5: A data-width pulse inside the framing slot produces no strobe. It does not realign the tracker and does not count as a framing pulse.
- R6: `sync_lost` goes high once (MISS_FRAMES+1)*4*SLOT_LEN + SLOT_LEN/2 clocks have passed since the last framing pulse. At the defaults this is two whole frames without one. While the flag is high no strobe is produced. The next framing pulse clears it.
- R7: `cnt_valid` is high for one clock at the end of each gate. Gates last `gate_len` clocks, and a `gate_len` of 0 acts as 1.
- R8: While `cnt_valid` is high, field i of `cnt_flat` (bits [i*CNT_W +: CNT_W]) holds the number of channel-i strobes seen in the gate that just ended. A strobe in the last clock of a gate counts toward the next gate. The fields hold until the next `cnt_valid`. The counters saturate at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Combined pulse line (asynchronous) |
| gate_len | input | GATE_W (24) | Gate length in clocks |
| ch_strobe | output | 3 | One-clock strobe for each recovered data pulse, one bit per channel |
| sync_lost | output | 1 | Framing lost; routing is blocked |
| cnt_valid | output | 1 | One-clock flag at the end of each gate |
| cnt_flat | output | 3*CNT_W (60) | Latched pulse counts, channel i in bits [i*CNT_W +: CNT_W] |

## Verification
The hardest state to reach from the ports is the boundary of framing loss. Routing must continue through the second frame with no framing pulse and stop in the third. A framing-slot pulse that is one sample too wide must also count as a missing framing pulse. Directed frames therefore drop the framing pulse, or replace it with a width-5 pulse in the framing slot, for exactly three frames while data pulses sit in every channel slot. A bench model of consecutive missed frames then predicts which of those data pulses must still appear as strobes. Seeded random frames mix framing-pulse widths, fake framing pulses and missing frames with data pulses limited to every other frame per channel, while gate counts are cross-checked against the strobes seen at the outputs.

// File: rtl/tdmx_pkg.sv
package tdmx_pkg;

    localparam int unsigned SLOTS    = 4;
    localparam int unsigned CHANS    = SLOTS - 1;
    localparam int unsigned WID_BITS = 8;

    typedef logic [1:0]          slot_t;
    typedef logic [WID_BITS-1:0] width_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_SYNC = 2'd1,
        EV_DATA = 2'd2
    } evt_kind_e;

    typedef struct packed {
        evt_kind_e kind;
        width_t    width;
    } pulse_evt_t;

    // Narrow pulses frame the stream; anything wider than half the nominal
    // data width is payload.
    function automatic evt_kind_e classify_width(input int unsigned hi_cycles,
                                                 input int unsigned nominal);
        return (hi_cycles <= nominal / 2) ? EV_SYNC : EV_DATA;
    endfunction

endpackage

// File: rtl/tdmx_line_sampler.sv
module tdmx_line_sampler
    import tdmx_pkg::*;
#(
    parameter int unsigned NOM_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output pulse_evt_t evt,
    output logic       rise
);

    logic   meta_q;
    logic   samp_q;
    logic   prev_q;
    width_t hi_cnt;
    logic   fall;

    assign rise = samp_q & ~prev_q;
    assign fall = prev_q & ~samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q    <= 1'b0;
            samp_q    <= 1'b0;
            prev_q    <= 1'b0;
            hi_cnt    <= '0;
            evt.kind  <= EV_NONE;
            evt.width <= '0;
        end else begin
            meta_q <= line_in;
            samp_q <= meta_q;
            prev_q <= samp_q;
            if (rise) begin
                hi_cnt <= width_t'(1);
            end else if (samp_q && hi_cnt != '1) begin
                hi_cnt <= hi_cnt + width_t'(1);
            end
            evt.kind  <= fall ? classify_width(32'(hi_cnt), NOM_W) : EV_NONE;
            evt.width <= hi_cnt;
        end
    end

    // R2: an event is only reported right after a sampled falling edge
    a_r2_event_after_fall: assert property (@(posedge clk) disable iff (rst)
        (evt.kind != EV_NONE) |-> ($past(prev_q) && !$past(samp_q)));

    // R2: every reported pulse was high for at least one sample
    a_r2_width_nonzero: assert property (@(posedge clk) disable iff (rst)
        (evt.kind != EV_NONE) |-> (evt.width != '0));

endmodule

// File: rtl/tdmx_slot_tracker.sv
module tdmx_slot_tracker
    import tdmx_pkg::*;
#(
    parameter int unsigned SLOT_LEN = 16,
    parameter int unsigned LOST_GAP = 200
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_hit,
    input  width_t sync_w,
    output slot_t  slot,
    output logic   lost
);

    localparam int unsigned POS_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam int unsigned GAP_W = $clog2(LOST_GAP + 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_LEN - 1);
    localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(LOST_GAP);

    logic [POS_W-1:0] pos_q;
    logic [GAP_W-1:0] gap_q;
    logic [POS_W-1:0] pos_seed;

    // Sync is recognised after its own width; start the slot that far in.
    assign pos_seed = (32'(sync_w) >= SLOT_LEN) ? POS_LAST : sync_w[POS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot  <= '0;
            pos_q <= '0;
            gap_q <= GAP_MAX;
            lost  <= 1'b1;
        end else if (sync_hit) begin
            slot  <= '0;
            pos_q <= pos_seed;
            gap_q <= '0;
            lost  <= 1'b0;
        end else begin
            if (pos_q == POS_LAST) begin
                pos_q <= '0;
                slot  <= slot + slot_t'(1);
            end else begin
                pos_q <= pos_q + POS_W'(1);
            end
            if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + GAP_W'(1);
                if (gap_q == GAP_MAX - GAP_W'(1)) begin
                    lost <= 1'b1;
                end
            end
        end
    end

    // R6: loss is declared only when the silence window just ran out
    a_r6_lost_needs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(lost) |-> ($past(gap_q) == GAP_MAX - GAP_W'(1)));

    // R6: a framing pulse always clears the loss flag
    a_r6_sync_clears_lost: assert property (@(posedge clk) disable iff (rst)
        sync_hit |=> !lost);

endmodule

// File: rtl/tdmx_gate_bank.sv
module tdmx_gate_bank #(
    parameter int unsigned NCH    = 3,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned GATE_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GATE_W-1:0]      gate_len,
    input  logic [NCH-1:0]         hit,
    output logic                   done,
    output logic [NCH*CNT_W-1:0]   tally
);

    logic [GATE_W-1:0] timer_q;
    logic [GATE_W:0]   timer_nx;
    logic              gate_end;

    assign timer_nx = {1'b0, timer_q} + {{GATE_W{1'b0}}, 1'b1};
    assign gate_end = timer_nx >= {1'b0, gate_len};

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            done    <= 1'b0;
        end else begin
            done    <= gate_end;
            timer_q <= gate_end ? '0 : timer_nx[GATE_W-1:0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [CNT_W-1:0] acc_q;
        logic [CNT_W-1:0] held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q  <= '0;
                held_q <= '0;
            end else if (gate_end) begin
                held_q <= acc_q;
                acc_q  <= CNT_W'(hit[g]);
            end else if (hit[g] && acc_q != '1) begin
                acc_q <= acc_q + CNT_W'(1);
            end
        end

        assign tally[g*CNT_W +: CNT_W] = held_q;
    end

    // R8: latched counts only change together with the valid flag
    a_r8_tally_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(tally));

    // R7: with a gate longer than one clock, valid never repeats back to back
    a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (done && gate_len > GATE_W'(1)) |=> !done);

endmodule

// File: rtl/tdm_pulse_demux.sv
module tdm_pulse_demux
    import tdmx_pkg::*;
#(
    parameter int unsigned NOM_W       = 8,
    parameter int unsigned SLOT_LEN    = 16,
    parameter int unsigned MISS_FRAMES = 2,
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned GATE_W      = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     line_in,
    input  logic [GATE_W-1:0]        gate_len,
    output logic [CHANS-1:0]         ch_strobe,
    output logic                     sync_lost,
    output logic                     cnt_valid,
    output logic [CHANS*CNT_W-1:0]   cnt_flat
);

    localparam int unsigned FRAME_LEN = SLOT_LEN * SLOTS;
    localparam int unsigned LOST_GAP  = (MISS_FRAMES + 1) * FRAME_LEN + SLOT_LEN / 2;

    pulse_evt_t evt;
    logic       rise;
    logic       sync_hit;
    logic       data_hit;
    slot_t      cur_slot;
    slot_t      start_q;
    logic [CHANS-1:0] strobe_q;

    tdmx_line_sampler #(
        .NOM_W (NOM_W)
    ) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .evt     (evt),
        .rise    (rise)
    );

    assign sync_hit = (evt.kind == EV_SYNC);
    assign data_hit = (evt.kind == EV_DATA);

    tdmx_slot_tracker #(
        .SLOT_LEN (SLOT_LEN),
        .LOST_GAP (LOST_GAP)
    ) u_tracker (
        .clk      (clk),
        .rst      (rst),
        .sync_hit (sync_hit),
        .sync_w   (evt.width),
        .slot     (cur_slot),
        .lost     (sync_lost)
    );

    // The slot is taken where the pulse starts; the route is decided at its end.
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= '0;
            strobe_q <= '0;
        end else begin
            if (rise) begin
                start_q <= cur_slot;
            end
            for (int c = 0; c < CHANS; c++) begin
                strobe_q[c] <= data_hit && !sync_lost && (start_q == slot_t'(c + 1));
            end
        end
    end

    assign ch_strobe = strobe_q;

    tdmx_gate_bank #(
        .NCH    (CHANS),
        .CNT_W  (CNT_W),
        .GATE_W (GATE_W)
    ) u_gates (
        .clk      (clk),
        .rst      (rst),
        .gate_len (gate_len),
        .hit      (strobe_q),
        .done     (cnt_valid),
        .tally    (cnt_flat)
    );

    // R4: never more than one channel strobes at once
    a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_strobe));

    // R4: strobes are a single clock wide
    a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (|ch_strobe) |=> !(|ch_strobe));

    // R6: nothing is routed while framing is lost
    a_r6_blocked_when_lost: assert property (@(posedge clk) disable iff (rst)
        (|ch_strobe) |-> !$past(sync_lost));

endmodule

// File: tb/sim_tdm_pulse_demux.sv
module sim_tdm_pulse_demux;

    localparam int NOM_W    = 8;
    localparam int SLOT_LEN = 16;
    localparam int FRAME    = 4 * SLOT_LEN;
    localparam int MISS     = 2;
    localparam int CNT_W    = 20;
    localparam int GATE_W   = 24;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  line_in = 1'b0;
    logic [GATE_W-1:0]     gate_len = 24'd300;
    logic [2:0]            ch_strobe;
    logic                  sync_lost;
    logic                  cnt_valid;
    logic [3*CNT_W-1:0]    cnt_flat;

    tdm_pulse_demux u0 (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .gate_len  (gate_len),
        .ch_strobe (ch_strobe),
        .sync_lost (sync_lost),
        .cnt_valid (cnt_valid),
        .cnt_flat  (cnt_flat)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int fall_cyc [3];
    int exp_tot [3];
    int obs_tot [3];
    int gcnt [3];
    logic [2:0] prev_s;
    int last_v;
    int exp_gap = 300;
    int nmiss = 99;
    int dw [3];
    int doff [3];
    bit [2:0] fired;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected routing comes from the frame model: a frame is routed if it has
    // a framing pulse or if at most MISS frames in a row have lacked one.
    function automatic bit frame_routed(input int w0);
        bit has_sync;
        has_sync = (w0 >= 1) && (w0 <= NOM_W / 2);
        if (has_sync) nmiss = 0;
        else if (nmiss < 99) nmiss++;
        return has_sync || (nmiss <= MISS);
    endfunction

    task automatic drive_frame(input int w0, input int off0, input bit [2:0] dat);
        logic [FRAME-1:0] pat;
        bit routed;
        pat = '0;
        for (int j = 0; j < w0; j++) pat[off0 + j] = 1'b1;
        for (int c = 0; c < 3; c++)
            if (dat[c])
                for (int j = 0; j < dw[c]; j++) pat[SLOT_LEN * (c + 1) + doff[c] + j] = 1'b1;
        routed = frame_routed(w0);
        for (int c = 0; c < 3; c++) if (dat[c] && routed) exp_tot[c]++;
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            line_in = pat[i];
            if (i > 0 && !pat[i] && pat[i-1] && (i - 1) >= SLOT_LEN)
                fall_cyc[(i - 1) / SLOT_LEN - 1] = cyc;
        end
    endtask

    task automatic set_data(input int w, input int off);
        for (int c = 0; c < 3; c++) begin dw[c] = w; doff[c] = off; end
    endtask

    task automatic compare_totals(input string req);
        set_data(6, 4);
        drive_frame(2, 0, 3'b000);
        for (int c = 0; c < 3; c++)
            chk(obs_tot[c] == exp_tot[c], req, obs_tot[c], exp_tot[c]);
    endtask

    task automatic do_reset(input int glen);
        @(negedge clk);
        rst = 1'b1;
        line_in = 1'b0;
        gate_len = GATE_W'(glen);
        exp_gap = (glen == 0) ? 1 : glen;
        nmiss = 99;
        repeat (4) @(negedge clk);
        chk(sync_lost == 1'b1, "R1 lost in reset", sync_lost, 1);
        chk(ch_strobe == 3'b000, "R1 strobe in reset", ch_strobe, 0);
        rst = 1'b0;
    endtask

    // Output monitor: gate contents, gate spacing and strobe latency.
    always @(negedge clk) begin
        if (rst) begin
            prev_s = '0;
            for (int c = 0; c < 3; c++) gcnt[c] = 0;
            last_v = -1;
        end else begin
            if (cnt_valid) begin
                for (int c = 0; c < 3; c++) begin
                    chk(int'(cnt_flat[c*CNT_W +: CNT_W]) == gcnt[c] - int'(prev_s[c]),
                        "R8 gate count", int'(cnt_flat[c*CNT_W +: CNT_W]),
                        gcnt[c] - int'(prev_s[c]));
                    gcnt[c] = int'(prev_s[c]);
                end
                if (last_v >= 0) chk(cyc - last_v == exp_gap, "R7 gate period", cyc - last_v, exp_gap);
                last_v = cyc;
            end
            for (int c = 0; c < 3; c++) begin
                if (ch_strobe[c]) begin
                    obs_tot[c]++;
                    gcnt[c]++;
                    chk(cyc - fall_cyc[c] == 4, "R4 strobe latency/channel", cyc - fall_cyc[c], 4);
                end
            end
            prev_s = ch_strobe;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++) begin
            exp_tot[c] = 0; obs_tot[c] = 0; fall_cyc[c] = -100;
        end
        gate_len = 24'd300;
        repeat (5) @(negedge clk);
        // R1: reset values
        chk(sync_lost == 1'b1, "R1 lost at reset", sync_lost, 1);
        chk(ch_strobe == 3'b000, "R1 strobe at reset", ch_strobe, 0);
        chk(cnt_valid == 1'b0, "R1 valid at reset", cnt_valid, 0);
        chk(cnt_flat == '0, "R1 counts at reset", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sync_lost == 1'b1, "R1 lost after reset", sync_lost, 1);

        // R3: basic lock and routing, all slots
        set_data(7, 4);
        drive_frame(2, 0, 3'b101);
        drive_frame(3, 0, 3'b010);
        drive_frame(1, 0, 3'b101);
        chk(sync_lost == 1'b0, "R3 locked", sync_lost, 0);
        compare_totals("R3 slot routing");

        // R2: widest framing pulse and narrowest data pulse
        set_data(5, 3);
        drive_frame(4, 0, 3'b111);
        drive_frame(4, 0, 3'b000);
        drive_frame(4, 0, 3'b111);
        chk(sync_lost == 1'b0, "R2 width-4 pulse is sync", sync_lost, 0);
        compare_totals("R2 width-5 pulse is data");

        // R5/R6: data-width pulse in the framing slot, three frames running
        set_data(8, 5);
        drive_frame(5, 3, 3'b111);
        drive_frame(5, 3, 3'b111);
        chk(sync_lost == 1'b0, "R6 still locked after two misses", sync_lost, 0);
        drive_frame(5, 3, 3'b111);
        chk(sync_lost == 1'b1, "R6 lost after third miss", sync_lost, 1);
        compare_totals("R5 sync-slot data ignored");
        chk(sync_lost == 1'b0, "R6 cleared by sync", sync_lost, 0);

        // R6: framing pulses simply absent
        set_data(6, 4);
        drive_frame(0, 0, 3'b001);
        drive_frame(0, 0, 3'b010);
        drive_frame(0, 0, 3'b100);
        drive_frame(0, 0, 3'b011);
        chk(sync_lost == 1'b1, "R6 lost on silence", sync_lost, 1);
        compare_totals("R6 blocked while lost");

        // Seeded random frames
        fired = '0;
        for (int f = 0; f < 150; f++) begin
            int r;
            int w0;
            int off0;
            bit [2:0] dat;
            r = int'($urandom_range(7, 0));
            off0 = 0;
            if (r == 0) w0 = 0;
            else if (r == 1) begin w0 = int'($urandom_range(7, 5)); off0 = 3; end
            else w0 = int'($urandom_range(4, 1));
            dat = '0;
            for (int c = 0; c < 3; c++) begin
                if (!fired[c] && $urandom_range(1, 0) == 1) dat[c] = 1'b1;
                dw[c] = int'($urandom_range(9, 5));
                doff[c] = int'($urandom_range(5, 3));
            end
            fired = dat;
            drive_frame(w0, off0, dat);
            if (f % 25 == 24) compare_totals("R3 random routing");
        end

        // R7: gate length 0 behaves as 1
        do_reset(0);
        set_data(6, 4);
        drive_frame(2, 0, 3'b011);
        drive_frame(2, 0, 3'b100);
        compare_totals("R7 single-clock gates");

        // R7/R8: another gate length
        do_reset(97);
        for (int f = 0; f < 6; f++) begin
            set_data(int'($urandom_range(9, 5)), int'($urandom_range(5, 3)));
            drive_frame(int'($urandom_range(4, 1)), 0, (f % 2 == 0) ? 3'b101 : 3'b010);
        end
        compare_totals("R8 counts with 97-clock gate");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule